// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the processor-side sequencer for a bus on which the address and the data share one set of lines. An internal requester presents a read or write request with an address, write data and a three-bit cycle kind. The sequencer accepts the request and runs a bus cycle through the phases T1, T2, T3, any number of wait phases, and T4. In T1 it drives the address together with an address-latch strobe. T2 turns the lines around: a read releases them, and a write puts its data on them. While the addressed device holds its ready input low, the sequencer adds whole-clock wait phases. The value on the lines is captured as read data at the clock that closes T4.

When no request is pending the sequencer sits in an idle phase with the lines released. A request that is present during T4 starts the next T1 on the very next clock, so back-to-back cycles need no idle clock between them. The shared lines are modelled as a separate output, input and output-enable. Any tristate buffer sits outside this block.

Top module: `mux_bus_seq`

## Requirements
- R1: While rst_n is low at a clock edge and after it is released, the sequencer is idle: bus_ale=0, bus_oe=0, rdata_valid=0, bus_kind=3'b111.
- R2: req_ack is high in the same cycle as req_valid when the sequencer is idle or in T4. The next clock is T1, with bus_ale=1, bus_oe=1 and bus_ado equal to the zero-extended request address.
- R3: T1, T2 and T3 each last exactly one clock, in that order. With bus_ready high at the end of T3, T4 follows, so a cycle takes at least four clocks.
- R4: When bus_ready is sampled low at the end of T3 or of a wait phase, one more wait phase follows. T4 follows the first clock on which bus_ready is sampled high.
- R5: In a read, bus_oe is low from T2 through T4. bus_adi[DW-1:0] sampled at the clock that ends T4 appears on rdata, and rdata_valid is high for exactly the following clock.
- R6: In a write, bus_oe is high and bus_ado equals the zero-extended write data from T2 through T4. bus_oe is low after T4 unless a new T1 starts.
- R7: A request present during T4 is acknowledged there, and T1 of the new cycle follows on the next clock with no idle clock.
- R8: In idle, bus_ale=0, bus_oe=0 and bus_kind=3'b111. bus_kind carries the request kind from T1 through the last wait phase and reads 3'b111 in T4.
- R9: req_valid and the request fields are ignored from T1 through the last wait phase: req_ack stays low, and the address and data driven in the running cycle do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 3 | Cycle kind shown on bus_kind during the cycle |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | Request accepted this cycle |
| rdata | output | DW | Captured read data |
| rdata_valid | output | 1 | rdata valid for one clock |
| bus_ado | output | max(AW,DW) | Value driven on the shared lines |
| bus_oe | output | 1 | Output enable of the shared lines |
| bus_adi | input | max(AW,DW) | Value seen on the shared lines |
| bus_ale | output | 1 | Address-latch strobe, high in T1 |
| bus_kind | output | 3 | Cycle kind, 3'b111 when passive |
| bus_ready | input | 1 | Device ready, sampled at end of T3 and wait phases |

## Verification
The bench builds the block with its defaults, AW=20 and DW=16. Because the address is four lines wider than the data, the zero fill of the upper lines during the data phases can be observed. Wait counts range from zero to four, and reads, writes, chained and isolated cycles are mixed. This exercises every phase transition, including wait phases followed directly by a back-to-back T1.

// File: rtl/bus_seq_pkg.sv
// Shared types for the multiplexed bus sequencer.
package bus_seq_pkg;
    localparam int KIND_W = 3;
    localparam logic [KIND_W-1:0] KIND_PASSIVE = 3'b111;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;
endpackage

// File: rtl/bus_seq_fsm.sv
// Phase controller: walks IDLE -> T1 -> T2 -> T3 -> (TW)* -> T4 and
// either returns to IDLE or starts the next T1 directly from T4.
// Assumes bus_ready is already synchronous to clk.
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   bus_ready,
    output logic   req_ack,
    output phase_t phase
);
    phase_t phase_nx;

    // A request is taken only when no cycle needs the lines next clock.
    assign req_ack = req_valid && (phase == PH_IDLE || phase == PH_T4);

    // Next-phase decode.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: phase_nx = req_valid ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = bus_ready ? PH_T4 : PH_TW;
            PH_TW:   phase_nx = bus_ready ? PH_T4 : PH_TW;
            PH_T4:   phase_nx = req_valid ? PH_T1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    p_t1_then_t2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T1 |=> phase == PH_T2);
    p_t2_then_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T2 |=> phase == PH_T3);
    p_wait_inserted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !bus_ready) |=> phase == PH_TW);
    p_ready_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && bus_ready) |=> phase == PH_T4);
    p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T4 && req_valid) |=> phase == PH_T1);
endmodule

// File: rtl/bus_seq_dpath.sv
// Datapath: holds the accepted request, decodes the shared-line drive,
// strobe and kind from the phase, and captures read data at end of T4.
// Assumes AW and DW are both at most BW; narrower values are zero-filled.
module bus_seq_dpath
    import bus_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int BW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              req_ack,
    input  logic              req_write,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [BW-1:0]     bus_adi,
    output logic [BW-1:0]     bus_ado,
    output logic              bus_oe,
    output logic              bus_ale,
    output logic [KIND_W-1:0] bus_kind,
    output logic [DW-1:0]     rdata,
    output logic              rdata_valid
);
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic              wr_q;
    logic [KIND_W-1:0] kind_q;
    logic              in_data;
    logic              in_busy;

    assign in_data = (phase == PH_T2) || (phase == PH_T3) ||
                     (phase == PH_TW) || (phase == PH_T4);
    assign in_busy = (phase == PH_T1) || (phase == PH_T2) ||
                     (phase == PH_T3) || (phase == PH_TW);

    // Request holding registers, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            kind_q  <= KIND_PASSIVE;
        end else if (req_ack) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            kind_q  <= req_kind;
        end
    end

    // Shared-line drive: address in T1, write data in the data phases.
    always_comb begin
        bus_ado = '0;
        if (phase == PH_T1)        bus_ado = BW'(addr_q);
        else if (in_data && wr_q)  bus_ado = BW'(wdata_q);
    end

    assign bus_oe   = (phase == PH_T1) || (in_data && wr_q);
    assign bus_ale  = (phase == PH_T1);
    assign bus_kind = in_busy ? kind_q : KIND_PASSIVE;

    // Read capture on the clock that ends T4 of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (phase == PH_T4) && !wr_q;
            if ((phase == PH_T4) && !wr_q) rdata <= bus_adi[DW-1:0];
        end
    end

    p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(phase == PH_T4 && !wr_q));
    p_request_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 || phase == PH_T3 || phase == PH_TW || phase == PH_T4)
        |-> ($stable(addr_q) && $stable(wdata_q) && $stable(wr_q)));
    p_release_after_t4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase == PH_T4) && phase == PH_IDLE) |-> !bus_oe);
    p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !wr_q) |-> !bus_oe);
endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed address/data bus sequencer: phase controller
// plus datapath. Assumes synchronous bus_ready and an external tristate.
module mux_bus_seq
    import bus_seq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    localparam int BW = (AW > DW) ? AW : DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ack,
    output logic [DW-1:0]     rdata,
    output logic              rdata_valid,
    output logic [BW-1:0]     bus_ado,
    output logic              bus_oe,
    input  logic [BW-1:0]     bus_adi,
    output logic              bus_ale,
    output logic [KIND_W-1:0] bus_kind,
    input  logic              bus_ready
);
    phase_t phase;

    bus_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .req_ack   (req_ack),
        .phase     (phase)
    );

    bus_seq_dpath #(.AW(AW), .DW(DW), .BW(BW)) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .req_ack     (req_ack),
        .req_write   (req_write),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_adi     (bus_adi),
        .bus_ado     (bus_ado),
        .bus_oe      (bus_oe),
        .bus_ale     (bus_ale),
        .bus_kind    (bus_kind),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    p_ack_starts_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (bus_ale && bus_oe));
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    p_kind_passive_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe && !req_ack && $past(!bus_oe) && bus_kind == KIND_PASSIVE) |-> !bus_ale);
endmodule

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int BW = 20;
    localparam logic [2:0] PASSIVE = 3'b111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]    req_kind = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack;
    logic [DW-1:0] rdata;
    logic          rdata_valid;
    logic [BW-1:0] bus_ado;
    logic          bus_oe;
    logic [BW-1:0] bus_adi = '0;
    logic          bus_ale;
    logic [2:0]    bus_kind;
    logic          bus_ready = 1'b1;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    bit pend_rd = 1'b0;
    logic [DW-1:0] pend_val = '0;
    // next request, used when chaining from T4
    logic nx_w; logic [2:0] nx_k; logic [AW-1:0] nx_a; logic [DW-1:0] nx_d;

    always #2 clk = ~clk;

    mux_bus_seq #(.AW(AW), .DW(DW)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected enable per phase (1=T1 2=T2 3=T3 4=TW 5=T4 0=idle).
    function automatic logic exp_oe(input int ph, input logic w);
        return (ph == 1) || (w && ph >= 2);
    endfunction
    function automatic logic [2:0] exp_kind(input int ph, input logic [2:0] k);
        return (ph >= 1 && ph <= 4) ? k : PASSIVE;
    endfunction
    function automatic logic [BW-1:0] exp_ado(input int ph, input logic [AW-1:0] a,
                                              input logic [DW-1:0] d);
        return (ph == 1) ? BW'(a) : BW'(d);
    endfunction

    task automatic step();
        @(posedge clk); @(negedge clk);
        chk("R5 rdata_valid", {31'd0, rdata_valid}, {31'd0, pend_rd});
        if (pend_rd) chk("R5 rdata", {16'd0, rdata}, {16'd0, pend_val});
        pend_rd = 1'b0;
    endtask

    task automatic put_req(input logic w, input logic [2:0] k, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
        req_valid = 1'b1; req_write = w; req_kind = k; req_addr = a; req_wdata = d;
        #0.1;
        chk(tag, {31'd0, req_ack}, 32'd1);
    endtask

    task automatic phase_chk(input int ph, input logic w, input logic [2:0] k,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
        chk("R3 ale", {31'd0, bus_ale}, {31'd0, ph == 1});
        chk(w ? "R6 oe" : "R5 oe", {31'd0, bus_oe}, {31'd0, exp_oe(ph, w)});
        chk("R8 kind", {29'd0, bus_kind}, {29'd0, exp_kind(ph, k)});
        if (ph == 1) chk("R2 address", {12'd0, bus_ado}, {12'd0, exp_ado(ph, a, d)});
        else if (w)  chk("R6 R9 wdata", {12'd0, bus_ado}, {12'd0, exp_ado(ph, a, d)});
    endtask

    // Runs one cycle whose request was already accepted at this negedge.
    task automatic xfer(input logic w, input logic [2:0] k, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int nwait,
                        input logic [DW-1:0] rv, input bit chain);
        step();                                   // T1
        phase_chk(1, w, k, a, d);
        req_valid = 1'b1; req_addr = ~a; req_wdata = ~d; req_kind = ~k;
        #0.1;
        chk("R9 no ack in T1", {31'd0, req_ack}, 32'd0);
        step();                                   // T2
        phase_chk(2, w, k, a, d);
        chk("R9 no ack in T2", {31'd0, req_ack}, 32'd0);
        bus_ready = (nwait == 0);
        step();                                   // T3
        phase_chk(3, w, k, a, d);
        req_valid = 1'b0;
        for (int i = 0; i < nwait; i++) begin
            step();                               // TW
            phase_chk(4, w, k, a, d);
            chk("R4 waits", {31'd0, bus_ale}, 32'd0);
            bus_ready = (i == nwait - 1);
        end
        step();                                   // T4
        phase_chk(5, w, k, a, d);
        bus_adi = BW'(rv) | 20'hA0000;
        pend_rd = !w; pend_val = rv;
        if (chain) put_req(nx_w, nx_k, nx_a, nx_d, "R7 ack in T4");
        else begin
            req_valid = 1'b0;
            #0.1;
            chk("R2 no ack without req", {31'd0, req_ack}, 32'd0);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            phase_chk(0, 1'b0, 3'd0, '0, '0);
            chk("R8 idle oe", {31'd0, bus_oe}, 32'd0);
        end
    endtask

    initial begin
        logic w; logic [2:0] k; logic [AW-1:0] a; logic [DW-1:0] d;
        int r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1 ale in reset", {31'd0, bus_ale}, 32'd0);
        chk("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
        chk("R1 rvalid in reset", {31'd0, rdata_valid}, 32'd0);
        chk("R1 kind in reset", {29'd0, bus_kind}, {29'd0, PASSIVE});
        rst_n = 1'b1;
        idle(2);

        // Directed: zero-wait read, 3-wait write, chained read after write.
        put_req(1'b0, 3'd5, 20'hFFFF0, 16'h0000, "R2 ack idle");
        xfer(1'b0, 3'd5, 20'hFFFF0, 16'h0000, 0, 16'hBEEF, 1'b0);
        idle(2);
        put_req(1'b1, 3'd6, 20'h00001, 16'hFFFF, "R2 ack idle");
        nx_w = 1'b0; nx_k = 3'd4; nx_a = 20'h12345; nx_d = 16'h0;
        xfer(1'b1, 3'd6, 20'h00001, 16'hFFFF, 3, 16'h0, 1'b1);
        xfer(1'b0, 3'd4, 20'h12345, 16'h0, 1, 16'h1234, 1'b0);
        idle(1);

        // Constrained random mix.
        w = 1'($urandom); k = 3'($urandom % 7); a = AW'($urandom); d = DW'($urandom);
        put_req(w, k, a, d, "R2 ack idle");
        for (int n = 0; n < 60; n++) begin
            bit ch;
            int nw;
            logic [DW-1:0] rv;
            ch = 1'($urandom); nw = int'($urandom % 5); rv = DW'($urandom);
            nx_w = 1'($urandom); nx_k = 3'($urandom % 7);
            nx_a = AW'($urandom); nx_d = DW'($urandom);
            xfer(w, k, a, d, nw, rv, ch);
            if (ch) begin
                w = nx_w; k = nx_k; a = nx_a; d = nx_d;
            end else begin
                idle(1 + int'($urandom % 2));
                w = nx_w; k = nx_k; a = nx_a; d = nx_d;
                put_req(w, k, a, d, "R2 ack idle");
            end
        end
        xfer(w, k, a, d, 0, 16'h5A5A, 1'b0);
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule